// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit datapath of an accumulator-style microcontroller core. Each cycle it combines the working register with a second byte, which may be an instruction literal or a byte read from the register file. The operation code selects the function. The incoming carry and digit-carry bits come from the core's status register. The block then produces an 8-bit result, a five-bit flag vector and a five-bit write-enable mask that says which flags this operation class may change.

The block covers the following operations:
- add, with and without carry;
- subtract, operand minus working register, with and without borrow;
- increment, decrement and two's-complement negate;
- complement, AND, inclusive OR and XOR;
- move and clear;
- 8-bit circular rotates and 9-bit rotates through carry, both left and right;
- BCD decimal adjust of the working register.

A small status register inside the block merges the new flags under the mask whenever `en_i` is high. Unmasked flags keep their previous values.

Top module: `accum_alu`

## Requirements
- R1: Flag vectors use bit 4 = negative, bit 3 = overflow, bit 2 = zero, bit 1 = digit carry, bit 0 = carry. The negative flag equals result bit 7. The zero flag is 1 exactly when the 8-bit result is 0. Bits not set in `flag_we_o` read 0 on `flags_o`.
- R2: Code 0 gives w + opnd. Code 1 gives w + opnd + carry_i. Carry is the carry out of bit 7. Digit carry is the carry out of bit 3. Overflow is set when the signed sum leaves the range -128..127. All five flags are enabled.
- R3: Code 2 gives opnd - w. Code 3 gives opnd - w - (1 - carry_i). Carry = 1 means no borrow occurred, and digit carry follows the same convention for the low nibble. Overflow is signed overflow. All five flags are enabled.
- R4: Code 4 gives opnd + 1, code 5 gives opnd - 1, and code 6 gives 0 - opnd. Each uses the add/subtract flag rules above, and all five flags are enabled.
- R5: Code 7 gives ~opnd, code 8 gives w & opnd, code 9 gives w | opnd, and code 10 gives w ^ opnd. Only the negative and zero flags are enabled.
- R6: Code 11 rotates opnd left by one bit circularly, and code 12 rotates it right by one bit circularly. Only the negative and zero flags are enabled.
- R7: Code 13 gives {opnd[6:0], carry_i} with carry = opnd[7]. Code 14 gives {carry_i, opnd[7:1]} with carry = opnd[0]. Carry, negative and zero are enabled.
- R8: Code 15 passes opnd through with negative and zero enabled. Code 16 gives result 0 with only the zero flag enabled, and that flag set to 1.
- R9: Code 17 decimal-adjusts w. It first adds 6 if w[3:0] > 9 or dcarry_i = 1. It then adds 0x60 if the intermediate high nibble is > 9, or carry_i = 1, or the first step carried out of bit 7. Carry is set exactly when this second correction is applied, and only carry is enabled.
- R10: `status_o` resets to 0. On a clock edge with `en_i` high, each enabled flag takes its new value and every other flag keeps its value. With `en_i` low, `status_o` is unchanged.
- R11: Codes 18 to 31 give result 0 with no flag enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Commit the flag update to the status register |
| op_i | input | 5 | Operation code |
| w_i | input | 8 | Working-register operand |
| opnd_i | input | 8 | Literal or register-file operand |
| carry_i | input | 1 | Current carry flag |
| dcarry_i | input | 1 | Current digit-carry flag |
| result_o | output | 8 | Operation result |
| flags_o | output | 5 | New flag values (masked) |
| flag_we_o | output | 5 | Per-flag write enable |
| status_o | output | 5 | Registered status flags |

## Verification
Two things meet at the same status-register edge: the masked write of the flags the current operation owns, and the hold of the flags it does not own. The sweep runs every operation back to back with changing carry inputs. Each arithmetic step therefore leaves all five status bits in some state, and the logic, rotate, clear or decimal-adjust step that follows rewrites only part of them. After every edge, the bench compares `status_o` with its own merge of the previous status, the new flags and the expected mask. This catches both a flag written out of turn and an owned flag that fails to update.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int FLAG_W = 5;

  localparam int FN  = 4;
  localparam int FOV = 3;
  localparam int FZ  = 2;
  localparam int FDC = 1;
  localparam int FC  = 0;

  typedef logic [FLAG_W-1:0] flag_t;

  localparam flag_t MASK_ALL = '1;
  localparam flag_t MASK_NZ  = flag_t'((1 << FN) | (1 << FZ));
  localparam flag_t MASK_Z   = flag_t'(1 << FZ);
  localparam flag_t MASK_C   = flag_t'(1 << FC);
  localparam flag_t MASK_NZC = flag_t'((1 << FN) | (1 << FZ) | (1 << FC));

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBB = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_NEG  = 5'd6,
    OP_COM  = 5'd7,
    OP_AND  = 5'd8,
    OP_IOR  = 5'd9,
    OP_XOR  = 5'd10,
    OP_RLN  = 5'd11,
    OP_RRN  = 5'd12,
    OP_RLC  = 5'd13,
    OP_RRC  = 5'd14,
    OP_MOV  = 5'd15,
    OP_CLR  = 5'd16,
    OP_DAW  = 5'd17
  } alu_op_e;
endpackage

// File: rtl/accalu_adder.sv
module accalu_adder
  import accalu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              hcout_o,
  output logic              ovf_o
);
  localparam int HI_W = DATA_W - NIB_W;

  logic [NIB_W:0] lo_sum;
  logic [HI_W:0]  hi_sum;

  // split chain exposes the nibble carry
  assign lo_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
  assign hi_sum  = {1'b0, a_i[DATA_W-1:NIB_W]} + {1'b0, b_i[DATA_W-1:NIB_W]}
                 + {{HI_W{1'b0}}, lo_sum[NIB_W]};
  assign sum_o   = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
  assign hcout_o = lo_sum[NIB_W];
  assign cout_o  = hi_sum[HI_W];
  assign ovf_o   = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (sum_o[DATA_W-1] != a_i[DATA_W-1]);
endmodule

// File: rtl/accalu_rot.sv
module accalu_rot
  import accalu_pkg::*;
(
  input  logic [DATA_W-1:0] val_i,
  input  logic              cin_i,
  input  logic              left_i,
  input  logic              thru_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  logic fill;

  always_comb begin
    if (left_i) begin
      fill   = thru_i ? cin_i : val_i[DATA_W-1];
      res_o  = {val_i[DATA_W-2:0], fill};
      cout_o = val_i[DATA_W-1];
    end else begin
      fill   = thru_i ? cin_i : val_i[0];
      res_o  = {fill, val_i[DATA_W-1:1]};
      cout_o = val_i[0];
    end
  end
endmodule

// File: rtl/accalu_decadj.sv
module accalu_decadj
  import accalu_pkg::*;
(
  input  logic [DATA_W-1:0] w_i,
  input  logic              c_i,
  input  logic              dc_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  localparam logic [DATA_W:0]   LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(6 << NIB_W);

  logic           lo_adj;
  logic           hi_adj;
  logic [DATA_W:0] step1;

  assign lo_adj = (w_i[NIB_W-1:0] > NIB_W'(9)) || dc_i;
  assign step1  = {1'b0, w_i} + (lo_adj ? LO_FIX : '0);
  assign hi_adj = (step1[DATA_W-1:NIB_W] > (DATA_W-NIB_W)'(9)) || c_i || step1[DATA_W];
  assign res_o  = step1[DATA_W-1:0] + (hi_adj ? HI_FIX : '0);
  assign cout_o = hi_adj;
endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accalu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              carry_i,
  input  logic              dcarry_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] flag_we_o,
  output logic [FLAG_W-1:0] status_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_cin, add_c, add_hc, add_ov;
  logic [DATA_W-1:0] rot_res;
  logic              rot_c, rot_left, rot_thru;
  logic [DATA_W-1:0] da_res;
  logic              da_c;

  logic [DATA_W-1:0] res;
  logic              f_c, f_dc, f_ov;
  flag_t             we, fl;
  flag_t             status_q;

  // adder operand steering; subtract is a + ~b + cin
  always_comb begin
    add_a   = w_i;
    add_b   = opnd_i;
    add_cin = 1'b0;
    case (op)
      OP_ADDC: add_cin = carry_i;
      OP_SUB:  begin add_a = opnd_i;  add_b = ~w_i; add_cin = 1'b1;    end
      OP_SUBB: begin add_a = opnd_i;  add_b = ~w_i; add_cin = carry_i; end
      OP_INC:  begin add_a = opnd_i;  add_b = '0;   add_cin = 1'b1;    end
      OP_DEC:  begin add_a = opnd_i;  add_b = '1;   add_cin = 1'b0;    end
      OP_NEG:  begin add_a = ~opnd_i; add_b = '0;   add_cin = 1'b1;    end
      default: ;
    endcase
  end

  accalu_adder u_adder (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_c),
    .hcout_o(add_hc),
    .ovf_o  (add_ov)
  );

  assign rot_left = (op == OP_RLN) || (op == OP_RLC);
  assign rot_thru = (op == OP_RLC) || (op == OP_RRC);

  accalu_rot u_rot (
    .val_i (opnd_i),
    .cin_i (carry_i),
    .left_i(rot_left),
    .thru_i(rot_thru),
    .res_o (rot_res),
    .cout_o(rot_c)
  );

  accalu_decadj u_decadj (
    .w_i   (w_i),
    .c_i   (carry_i),
    .dc_i  (dcarry_i),
    .res_o (da_res),
    .cout_o(da_c)
  );

  always_comb begin
    res  = '0;
    f_c  = 1'b0;
    f_dc = 1'b0;
    f_ov = 1'b0;
    we   = '0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_INC, OP_DEC, OP_NEG: begin
        res  = add_sum;
        f_c  = add_c;
        f_dc = add_hc;
        f_ov = add_ov;
        we   = MASK_ALL;
      end
      OP_COM: begin res = ~opnd_i;        we = MASK_NZ; end
      OP_AND: begin res = w_i & opnd_i;   we = MASK_NZ; end
      OP_IOR: begin res = w_i | opnd_i;   we = MASK_NZ; end
      OP_XOR: begin res = w_i ^ opnd_i;   we = MASK_NZ; end
      OP_RLN, OP_RRN: begin res = rot_res; we = MASK_NZ; end
      OP_RLC, OP_RRC: begin res = rot_res; f_c = rot_c; we = MASK_NZC; end
      OP_MOV: begin res = opnd_i;         we = MASK_NZ; end
      OP_CLR: begin res = '0;             we = MASK_Z;  end
      OP_DAW: begin res = da_res; f_c = da_c; we = MASK_C; end
      default: ;
    endcase
  end

  always_comb begin
    fl      = '0;
    fl[FN]  = res[DATA_W-1];
    fl[FOV] = f_ov;
    fl[FZ]  = (res == '0);
    fl[FDC] = f_dc;
    fl[FC]  = f_c;
  end

  assign result_o  = res;
  assign flags_o   = fl & we;
  assign flag_we_o = we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   status_q <= '0;
    else if (en_i) status_q <= (status_q & ~we) | (fl & we);
  end

  assign status_o = status_q;

  // R10: idle cycles leave the status register alone
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(status_o));

  // R10: flags outside the mask survive a committed update
  a_r10_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((status_o & ~$past(flag_we_o)) == ($past(status_o) & ~$past(flag_we_o))));

  // R8: clear yields zero and writes only Z, set
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd16) |-> (result_o == '0 && flag_we_o == MASK_Z && flags_o[FZ]));

  // R5: logic class never touches OV, DC or C
  a_r5_logic_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 5'd7 && op_i <= 5'd10) |-> (flag_we_o[FOV] == 1'b0 && flag_we_o[FDC] == 1'b0
                                         && flag_we_o[FC] == 1'b0));

  // R11: unused codes are inert
  a_r11_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 5'd17) |-> (result_o == '0 && flag_we_o == '0));

  // R1: masked-off flags read as zero
  a_r1_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o & ~flag_we_o) == '0));
endmodule

// File: tb/accum_alu_bench.sv
module accum_alu_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] w_i = '0;
  logic [7:0] opnd_i = '0;
  logic       carry_i = 1'b0;
  logic       dcarry_i = 1'b0;
  logic [7:0] result_o;
  logic [4:0] flags_o;
  logic [4:0] flag_we_o;
  logic [4:0] status_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] stat_exp = '0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  accum_alu u_accum_alu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .op_i     (op_i),
    .w_i      (w_i),
    .opnd_i   (opnd_i),
    .carry_i  (carry_i),
    .dcarry_i (dcarry_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .flag_we_o(flag_we_o),
    .status_o (status_o)
  );

  function automatic string req_of(int op);
    if (op <= 1)  return "R2 (R1 flags)";
    if (op <= 3)  return "R3 (R1 flags)";
    if (op <= 6)  return "R4 (R1 flags)";
    if (op <= 10) return "R5 (R1 flags)";
    if (op <= 12) return "R6 (R1 flags)";
    if (op <= 14) return "R7 (R1 flags)";
    if (op <= 16) return "R8 (R1 flags)";
    if (op == 17) return "R9";
    return "R11";
  endfunction

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {result, masked flags, mask}
  function automatic logic [17:0] model(int op, int w, int b, int c, int dc);
    int r, t, cin, bo, lo;
    int fc, fdc, fov, hi;
    logic [4:0] we;
    logic [4:0] fl;
    r = 0; fc = 0; fdc = 0; fov = 0; we = 5'b00000;
    case (op)
      0, 1: begin
        cin = (op == 1) ? c : 0;
        r   = w + b + cin;
        fc  = (r > 255);
        fdc = ((w % 16) + (b % 16) + cin) > 15;
        t   = sx(w) + sx(b) + cin;
        fov = (t > 127 || t < -128);
        we  = 5'b11111;
      end
      2, 3: begin
        bo  = (op == 3) ? 1 - c : 0;
        r   = b - w - bo;
        fc  = (r >= 0);
        fdc = ((b % 16) - (w % 16) - bo) >= 0;
        t   = sx(b) - sx(w) - bo;
        fov = (t > 127 || t < -128);
        we  = 5'b11111;
      end
      4: begin
        r = b + 1; fc = (r > 255); fdc = (b % 16) == 15;
        t = sx(b) + 1; fov = (t > 127); we = 5'b11111;
      end
      5: begin
        r = b - 1; fc = (b != 0); fdc = (b % 16) != 0;
        t = sx(b) - 1; fov = (t < -128); we = 5'b11111;
      end
      6: begin
        r = 0 - b; fc = (b == 0); fdc = (b % 16) == 0;
        t = -sx(b); fov = (t > 127); we = 5'b11111;
      end
      7:  begin r = 255 - b; we = 5'b10100; end
      8:  begin r = w & b;   we = 5'b10100; end
      9:  begin r = w | b;   we = 5'b10100; end
      10: begin r = w ^ b;   we = 5'b10100; end
      11: begin r = (b * 2) % 256 + b / 128;     we = 5'b10100; end
      12: begin r = b / 2 + (b % 2) * 128;       we = 5'b10100; end
      13: begin r = (b * 2) % 256 + c; fc = b / 128; we = 5'b10101; end
      14: begin r = b / 2 + c * 128;   fc = b % 2;   we = 5'b10101; end
      15: begin r = b; we = 5'b10100; end
      16: begin r = 0; we = 5'b00100; end
      17: begin
        lo = ((w % 16) > 9 || dc != 0) ? 6 : 0;
        t  = w + lo;
        hi = (((t / 16) % 16) > 9 || c != 0 || t > 255) ? 1 : 0;
        r  = t + hi * 96;
        fc = hi;
        we = 5'b00001;
      end
      default: begin r = 0; we = 5'b00000; end
    endcase
    r  = r & 255;
    fl = {r[7] != 1'b0 ? 1'b1 : 1'b0, fov != 0, r == 0, fdc != 0, fc != 0};
    fl[4] = (r >= 128);
    return {r[7:0], fl & we, we};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int op, int w, int b, int c, int dc, bit en);
    logic [17:0] e;
    @(negedge clk_i);
    op_i = 5'(op); w_i = 8'(w); opnd_i = 8'(b);
    carry_i = c[0]; dcarry_i = dc[0]; en_i = en;
    #1;
    e = model(op, w, b, c, dc);
    check(req_of(op), {14'd0, result_o, flags_o, flag_we_o}, {14'd0, e});
    if (en) stat_exp = (stat_exp & ~e[4:0]) | e[9:5];
    @(posedge clk_i);
    #1;
    check("R10 status merge", {27'd0, status_o}, {27'd0, stat_exp});
  endtask

  initial begin
    logic [7:0] bvals [8];
    bvals = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'h81, 8'hF0, 8'hFF};
    repeat (3) @(posedge clk_i);
    #1;
    check("R10 reset status", {27'd0, status_o}, 32'd0);
    rst_ni = 1'b1;

    // R2..R8: near-exhaustive sweep, ops interleaved so masks meet at the status edge
    for (int w = 0; w < 256; w++)
      for (int k = 0; k < 8; k++)
        for (int c = 0; c < 2; c++)
          for (int op = 0; op < 17; op++)
            step(op, w, int'(bvals[(k + op) % 8]), c, (c + w) % 2, 1'b1);

    // R9: decimal adjust over every w and both incoming flags
    for (int w = 0; w < 256; w++)
      for (int cd = 0; cd < 4; cd++)
        step(17, w, 8'h5A, cd / 2, cd % 2, 1'b1);

    // R9: worked BCD case 0x38 + 0x29 = 0x61 -> 0x67
    step(0, 8'h38, 8'h29, 0, 0, 1'b1);
    step(17, 8'h61, 0, int'(status_o[0]), int'(status_o[1]), 1'b1);
    check("R9 bcd 38+29", {24'd0, result_o}, 32'h67);

    // R10: en_i low holds status whatever the op
    step(0, 8'hFF, 8'h01, 0, 0, 1'b1);
    for (int op = 0; op < 32; op++) step(op, op * 7, 255 - op, op % 2, 0, 1'b0);
    check("R10 hold after idle", {27'd0, status_o}, {27'd0, stat_exp});

    // R11: unused codes
    for (int op = 18; op < 32; op++) step(op, 8'hA5, 8'h3C, 1, 1, 1'b1);

    // R1: zero and negative spot checks
    step(8, 8'hF0, 8'h0F, 0, 0, 1'b1);
    check("R1 zero flag", {31'd0, flags_o[2]}, 32'd1);
    step(15, 0, 8'h80, 0, 0, 1'b1);
    check("R1 negative flag", {31'd0, flags_o[4]}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule